// File: doc/BRIEF.md
# Audio DMA Control and Interrupt Registers

This block is the byte-wide register front end of a period-based audio DMA engine. Software programs a 32-bit first address and a 32-bit inclusive last address through single-byte registers, sets the burst shape, bus locking and a FIFO watermark, and then fires a one-shot start command. A behavioural address walker stands in for the bus master. While running, it issues one word address for each beat that the surrounding logic accepts. It stops by itself after issuing the word that covers the last address, and it raises a done event.

Six status sources are held in a write-one-to-clear status register: error, lost, retry, done, FIFO full and FIFO empty. Only done comes from the walker; the other five arrive as pulses on input pins. Two independent gating registers, a mute and a mask, decide which latched sources may drive the single interrupt line. The status register always reads back the raw bits. A stop command aborts a period without raising done.

Top module: `audio_dma_ctrl`

## Requirements
- R1: After reset the walker is idle and the interrupt is low. Reads return 0x00 at 0x00, 0x01 and 0x0C, 0x3F at mute (0x0D) and 0xFF at mask (0x0E).
- R2: The first address is written as four little-endian bytes at 0x04..0x07 and the last address at 0x08..0x0B, so the lowest offset holds bits 7..0. Each byte reads back at its own offset.
- R3: Writing a byte with bit 0 set to offset 0x01 loads the first address into the walker and sets the run flag, which reads as bit 0 of 0x01. A write there with bit 0 clear has no effect.
- R4: While running, `beat` is high exactly when `beat_ok` is high, and `beat_addr` shows the current word address. Each beat advances the address by 4 bytes, and idle cycles in between do not disturb the sequence.
- R5: The last address is inclusive, so a period of P bytes issues P/4 beats and the final beat is at last-3. On the cycle after the final beat, run reads 0 and status bit 2 (done) is 1.
- R6: Writing a byte with bit 0 set to offset 0x02 clears the run flag at once and does not set done.
- R7: Configuration byte 0x00 holds these fields: bit 0 is burst enable, bits 2..1 select the burst length (0 gives 4 beats, 1 gives 8, 2 or 3 give 16), and bit 3 is bus lock. Bit 7 produces a one-cycle `fifo_flush` pulse and reads back as 0; the other bits read back as written.
- R8: Offset 0x03 is an 8-bit FIFO watermark that drives `fifo_level_thr` and reads back.
- R9: Status at 0x0C uses these bits: 5 error, 4 lost, 3 retry, 2 done, 1 full, 0 empty. A source pulse sets its bit, and writing 1 to a bit clears it. A set and a clear in the same cycle leave the bit set.
- R10: `irq` is high when some status bit is set whose mute bit (0x0D, same layout as status) is 0 and whose mask bit is 0. The mask at 0x0E uses bit 7 for done and bits 5, 4, 3, 1 and 0 for the other sources. All-ones mute holds `irq` low.
- R11: Reading 0x0C returns the raw status bits whatever the mute and mask settings are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Byte write strobe |
| reg_addr | input | 8 | Register offset for reads and writes |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| beat_ok | input | 1 | Bus accepts one word this cycle |
| ev_error | input | 1 | Error source pulse |
| ev_lost | input | 1 | Lost source pulse |
| ev_retry | input | 1 | Retry source pulse |
| ev_full | input | 1 | FIFO full source pulse |
| ev_empty | input | 1 | FIFO empty source pulse |
| run | output | 1 | Walker active |
| beat | output | 1 | A word address is issued this cycle |
| beat_addr | output | 32 | Current word address |
| burst_en | output | 1 | Burst mode enable |
| burst_len_sel | output | 2 | Burst length selector |
| burst_beats | output | 5 | Decoded burst length in beats |
| bus_lock | output | 1 | Bus lock enable |
| fifo_flush | output | 1 | One-cycle FIFO reset pulse |
| fifo_level_thr | output | 8 | FIFO watermark |
| irq | output | 1 | Interrupt line |

## Verification
On every cycle the assertions check the walker's stepping by one word per beat. They also check that the final beat is followed by done with the walker idle, that start and stop commands take effect on the next cycle, and that the interrupt never rises while all sources are muted or while no status bit is set. The bench scenarios are needed for the rest: the byte ordering of the address registers, the exact beat count and last address of an inclusive period, the combined effect of mute and mask on one source, and the rule that a set wins over a clear in the same cycle. Only the scenarios can also show that a stop command leaves done clear and that status reads stay raw.

// File: rtl/audio_dma_pkg.sv
package audio_dma_pkg;

  localparam int OFS_CFG  = 'h00;
  localparam int OFS_GO   = 'h01;
  localparam int OFS_HALT = 'h02;
  localparam int OFS_THR  = 'h03;
  localparam int OFS_SADR = 'h04;

  localparam int ST_EMPTY = 0;
  localparam int ST_FULL  = 1;
  localparam int ST_DONE  = 2;
  localparam int ST_RETRY = 3;
  localparam int ST_LOST  = 4;
  localparam int ST_ERROR = 5;
  localparam int ST_BITS  = 6;

  // Burst length selector to beat count; 3 is treated like 2.
  function automatic logic [4:0] burst_beats_of(input logic [1:0] sel);
    case (sel)
      2'd0:    return 5'd4;
      2'd1:    return 5'd8;
      default: return 5'd16;
    endcase
  endfunction

  // Mask byte to per-source mask: done lives in bit 7, others in place.
  function automatic logic [ST_BITS-1:0] mask_per_src(input logic [7:0] m);
    return {m[5], m[4], m[3], m[7], m[1], m[0]};
  endfunction

  function automatic logic irq_any(input logic [ST_BITS-1:0] stat,
                                   input logic [ST_BITS-1:0] mute,
                                   input logic [7:0]         mask);
    return |(stat & ~mute & ~mask_per_src(mask));
  endfunction

endpackage

// File: rtl/adma_bus_regs.sv
module adma_bus_regs
  import audio_dma_pkg::*;
#(
  parameter int ADDR_BYTES = 4,
  parameter int OFS_W      = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_wr,
  input  logic [OFS_W-1:0]        reg_addr,
  input  logic [7:0]              reg_wdata,
  output logic [7:0]              reg_rdata,
  input  logic                    run,
  input  logic [ST_BITS-1:0]      stat,
  output logic                    go_hit,
  output logic                    halt_hit,
  output logic [ST_BITS-1:0]      stat_clr,
  output logic [8*ADDR_BYTES-1:0] first_addr,
  output logic [8*ADDR_BYTES-1:0] last_addr,
  output logic [6:0]              cfg,
  output logic                    fifo_flush,
  output logic [7:0]              thr,
  output logic [ST_BITS-1:0]      mute,
  output logic [7:0]              mask
);
  localparam int OFS_EADR = OFS_SADR + ADDR_BYTES;
  localparam int OFS_STAT = OFS_EADR + ADDR_BYTES;
  localparam int OFS_MUTE = OFS_STAT + 1;
  localparam int OFS_MASK = OFS_STAT + 2;

  function automatic logic hit(input logic [OFS_W-1:0] a, input int ofs);
    return a == OFS_W'(ofs);
  endfunction

  assign go_hit   = reg_wr && hit(reg_addr, OFS_GO)   && reg_wdata[0];
  assign halt_hit = reg_wr && hit(reg_addr, OFS_HALT) && reg_wdata[0];
  assign stat_clr = (reg_wr && hit(reg_addr, OFS_STAT)) ? reg_wdata[ST_BITS-1:0] : '0;

  for (genvar b = 0; b < ADDR_BYTES; b++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        first_addr[8*b +: 8] <= '0;
        last_addr[8*b +: 8]  <= '0;
      end else if (reg_wr) begin
        if (hit(reg_addr, OFS_SADR + b)) first_addr[8*b +: 8] <= reg_wdata;
        if (hit(reg_addr, OFS_EADR + b)) last_addr[8*b +: 8]  <= reg_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg        <= '0;
      fifo_flush <= 1'b0;
      thr        <= '0;
      mute       <= '1;
      mask       <= '1;
    end else begin
      fifo_flush <= reg_wr && hit(reg_addr, OFS_CFG) && reg_wdata[7];
      if (reg_wr) begin
        if (hit(reg_addr, OFS_CFG))  cfg  <= reg_wdata[6:0];
        if (hit(reg_addr, OFS_THR))  thr  <= reg_wdata;
        if (hit(reg_addr, OFS_MUTE)) mute <= reg_wdata[ST_BITS-1:0];
        if (hit(reg_addr, OFS_MASK)) mask <= reg_wdata;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (hit(reg_addr, OFS_CFG))  reg_rdata = {1'b0, cfg};
    if (hit(reg_addr, OFS_GO))   reg_rdata = {7'd0, run};
    if (hit(reg_addr, OFS_THR))  reg_rdata = thr;
    if (hit(reg_addr, OFS_STAT)) reg_rdata = {{(8-ST_BITS){1'b0}}, stat};
    if (hit(reg_addr, OFS_MUTE)) reg_rdata = {{(8-ST_BITS){1'b0}}, mute};
    if (hit(reg_addr, OFS_MASK)) reg_rdata = mask;
    for (int b = 0; b < ADDR_BYTES; b++) begin
      if (hit(reg_addr, OFS_SADR + b)) reg_rdata = first_addr[8*b +: 8];
      if (hit(reg_addr, OFS_EADR + b)) reg_rdata = last_addr[8*b +: 8];
    end
  end
endmodule

// File: rtl/adma_walker.sv
module adma_walker #(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_hit,
  input  logic              halt_hit,
  input  logic              beat_ok,
  input  logic [ADDR_W-1:0] first_addr,
  input  logic [ADDR_W-1:0] last_addr,
  output logic              run,
  output logic              beat,
  output logic              beat_last,
  output logic [ADDR_W-1:0] cur_addr
);
  localparam logic [ADDR_W:0] SPAN = (ADDR_W+1)'(WORD_BYTES - 1);

  // The word at cur covers cur..cur+WORD-1; final once that reaches last.
  function automatic logic covers_last(input logic [ADDR_W-1:0] cur,
                                       input logic [ADDR_W-1:0] last);
    return ({1'b0, cur} + SPAN) >= {1'b0, last};
  endfunction

  assign beat      = run && beat_ok;
  assign beat_last = beat && covers_last(cur_addr, last_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= 1'b0;
      cur_addr <= '0;
    end else if (halt_hit) begin
      run <= 1'b0;
    end else if (go_hit) begin
      run      <= 1'b1;
      cur_addr <= first_addr;
    end else if (beat) begin
      cur_addr <= cur_addr + ADDR_W'(WORD_BYTES);
      if (beat_last) run <= 1'b0;
    end
  end
endmodule

// File: rtl/adma_irq_status.sv
module adma_irq_status
  import audio_dma_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ST_BITS-1:0] src_set,
  input  logic [ST_BITS-1:0] stat_clr,
  input  logic [ST_BITS-1:0] mute,
  input  logic [7:0]         mask,
  output logic [ST_BITS-1:0] stat,
  output logic               irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat <= '0;
    else        stat <= (stat & ~stat_clr) | src_set;
  end

  assign irq = irq_any(stat, mute, mask);
endmodule

// File: rtl/audio_dma_ctrl.sv
module audio_dma_ctrl
  import audio_dma_pkg::*;
#(
  parameter int ADDR_BYTES = 4,
  parameter int WORD_BYTES = 4,
  parameter int OFS_W      = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_wr,
  input  logic [OFS_W-1:0]        reg_addr,
  input  logic [7:0]              reg_wdata,
  output logic [7:0]              reg_rdata,
  input  logic                    beat_ok,
  input  logic                    ev_error,
  input  logic                    ev_lost,
  input  logic                    ev_retry,
  input  logic                    ev_full,
  input  logic                    ev_empty,
  output logic                    run,
  output logic                    beat,
  output logic [8*ADDR_BYTES-1:0] beat_addr,
  output logic                    burst_en,
  output logic [1:0]              burst_len_sel,
  output logic [4:0]              burst_beats,
  output logic                    bus_lock,
  output logic                    fifo_flush,
  output logic [7:0]              fifo_level_thr,
  output logic                    irq
);
  localparam int ADDR_W = 8 * ADDR_BYTES;

  logic                go_hit, halt_hit, beat_last;
  logic [ST_BITS-1:0]  stat, stat_clr, mute, src_set;
  logic [7:0]          mask;
  logic [6:0]          cfg;
  logic [ADDR_W-1:0]   first_addr, last_addr;

  adma_bus_regs #(.ADDR_BYTES(ADDR_BYTES), .OFS_W(OFS_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .run(run), .stat(stat),
    .go_hit(go_hit), .halt_hit(halt_hit), .stat_clr(stat_clr),
    .first_addr(first_addr), .last_addr(last_addr), .cfg(cfg),
    .fifo_flush(fifo_flush), .thr(fifo_level_thr), .mute(mute), .mask(mask)
  );

  adma_walker #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_walk (
    .clk(clk), .rst_n(rst_n), .go_hit(go_hit), .halt_hit(halt_hit),
    .beat_ok(beat_ok), .first_addr(first_addr), .last_addr(last_addr),
    .run(run), .beat(beat), .beat_last(beat_last), .cur_addr(beat_addr)
  );

  always_comb begin
    src_set           = '0;
    src_set[ST_ERROR] = ev_error;
    src_set[ST_LOST]  = ev_lost;
    src_set[ST_RETRY] = ev_retry;
    src_set[ST_DONE]  = beat_last;
    src_set[ST_FULL]  = ev_full;
    src_set[ST_EMPTY] = ev_empty;
  end

  adma_irq_status u_irq (
    .clk(clk), .rst_n(rst_n), .src_set(src_set), .stat_clr(stat_clr),
    .mute(mute), .mask(mask), .stat(stat), .irq(irq)
  );

  assign burst_en      = cfg[0];
  assign burst_len_sel = cfg[2:1];
  assign burst_beats   = burst_beats_of(cfg[2:1]);
  assign bus_lock      = cfg[3];
endmodule

// File: rtl/audio_dma_ctrl_checker.sv
module audio_dma_ctrl_checker
  import audio_dma_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               run,
  input logic               beat,
  input logic               beat_last,
  input logic               go_hit,
  input logic               halt_hit,
  input logic [ADDR_W-1:0]  cur_addr,
  input logic [ST_BITS-1:0] stat,
  input logic [ST_BITS-1:0] mute,
  input logic               irq
);
  AST_GO_STARTS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    go_hit && !halt_hit |=> run); // R3

  AST_STEP_ONE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    beat && !beat_last && !go_hit && !halt_hit
      |=> run && cur_addr == $past(cur_addr) + ADDR_W'(WORD_BYTES)); // R4

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last && !go_hit |=> !run && stat[ST_DONE]); // R5

  AST_HALT_STOPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    halt_hit |=> !run); // R6

  AST_MUTE_ALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    mute == '1 |-> !irq); // R10

  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> stat != '0); // R10
endmodule

bind audio_dma_ctrl audio_dma_ctrl_checker #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .beat(beat), .beat_last(beat_last),
  .go_hit(go_hit), .halt_hit(halt_hit), .cur_addr(beat_addr), .stat(stat),
  .mute(mute), .irq(irq)
);

// File: tb/audio_dma_ctrl_test.sv
`timescale 1ns/1ps
module audio_dma_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        beat_ok = 1'b0;
  logic        ev_error = 0, ev_lost = 0, ev_retry = 0, ev_full = 0, ev_empty = 0;
  logic        run, beat, burst_en, bus_lock, fifo_flush, irq;
  logic [31:0] beat_addr;
  logic [1:0]  burst_len_sel;
  logic [4:0]  burst_beats;
  logic [7:0]  fifo_level_thr;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  always #2.5 clk = ~clk;

  audio_dma_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .beat_ok(beat_ok),
    .ev_error(ev_error), .ev_lost(ev_lost), .ev_retry(ev_retry),
    .ev_full(ev_full), .ev_empty(ev_empty), .run(run), .beat(beat),
    .beat_addr(beat_addr), .burst_en(burst_en), .burst_len_sel(burst_len_sel),
    .burst_beats(burst_beats), .bus_lock(bus_lock), .fifo_flush(fifo_flush),
    .fifo_level_thr(fifo_level_thr), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Write spans one rising edge; returns at the following falling edge.
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic wr32(input logic [7:0] base, input logic [31:0] v);
    for (int i = 0; i < 4; i++) wr(base + 8'(i), v[8*i +: 8]);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(8'h00, d); check("R1 cfg", d, 8'h00);
    rd(8'h01, d); check("R1 run read", d, 8'h00);
    rd(8'h0C, d); check("R1 status", d, 8'h00);
    rd(8'h0D, d); check("R1 mute", d, 8'h3F);
    rd(8'h0E, d); check("R1 mask", d, 8'hFF);
    check("R1 irq", irq, 0);
    check("R1 run", run, 0);
  endtask

  task automatic t_cfg();
    logic [7:0] d;
    wr(8'h00, 8'h0B);
    check("R7 burst_en", burst_en, 1);
    check("R7 sel 1", burst_len_sel, 2'd1);
    check("R7 beats 8", burst_beats, 5'd8);
    check("R7 lock", bus_lock, 1);
    wr(8'h00, 8'h04);
    check("R7 beats 16", burst_beats, 5'd16);
    check("R7 lock off", bus_lock, 0);
    wr(8'h00, 8'h01);
    check("R7 beats 4", burst_beats, 5'd4);
    wr(8'h00, 8'h88);
    check("R7 flush pulse", fifo_flush, 1);
    @(negedge clk);
    check("R7 flush ends", fifo_flush, 0);
    rd(8'h00, d); check("R7 bit7 reads 0", d, 8'h08);
  endtask

  task automatic t_thr();
    logic [7:0] d;
    wr(8'h03, 8'd126);
    check("R8 port", fifo_level_thr, 8'd126);
    rd(8'h03, d); check("R8 read", d, 8'd126);
  endtask

  task automatic t_addr();
    logic [7:0] d;
    wr32(8'h04, 32'h12345678);
    wr32(8'h08, 32'h9ABCDEF0);
    rd(8'h04, d); check("R2 start b0", d, 8'h78);
    rd(8'h05, d); check("R2 start b1", d, 8'h56);
    rd(8'h07, d); check("R2 start b3", d, 8'h12);
    rd(8'h08, d); check("R2 stop b0", d, 8'hF0);
    rd(8'h0B, d); check("R2 stop b3", d, 8'h9A);
    wr(8'h01, 8'h00);
    check("R3 bit0 clear ignored", run, 0);
    wr(8'h01, 8'h01);
    check("R3 run set", run, 1);
    check("R2 R3 first addr", beat_addr, 32'h12345678);
    check("R4 no beat without ok", beat, 0);
    rd(8'h01, d); check("R3 run readback", d, 8'h01);
    wr(8'h02, 8'h01);
    check("R6 halt", run, 0);
  endtask

  // Runs one period with a beat_ok pattern; checks count, addresses, done timing.
  task automatic t_period(input logic [31:0] first, input logic [31:0] last,
                          input bit gappy, input string tag);
    int n = 0;
    int exp_n;
    logic [31:0] exp_a;
    logic [7:0] d;
    bit done_seen = 0;
    exp_n = int'((last - first + 1) / 4);
    exp_a = first;
    wr(8'h0C, 8'h3F);
    wr32(8'h04, first);
    wr32(8'h08, last);
    wr(8'h01, 8'h01);
    reg_addr = 8'h0C;
    for (int cyc = 0; cyc < 40 && !done_seen; cyc++) begin
      beat_ok = gappy ? cyc[0] : 1'b1;
      #0.5;
      if (beat) begin
        if (beat_addr !== exp_a) check({tag, " R4 addr"}, beat_addr, exp_a);
        exp_a += 4;
        n++;
        if (n == exp_n) begin
          @(negedge clk);
          beat_ok = 1'b0;
          #0.5;
          check({tag, " R5 run off after final"}, run, 0);
          check({tag, " R5 done next cycle"}, reg_rdata[2], 1);
          done_seen = 1;
        end
      end
      if (!done_seen) @(negedge clk);
    end
    beat_ok = 1'b0;
    check({tag, " R5 beat count"}, n, exp_n);
    check({tag, " R5 final addr"}, exp_a - 4, last - 3);
    rd(8'h0C, d); check({tag, " R5 status"}, d, 8'h04);
  endtask

  task automatic t_halt();
    logic [7:0] d;
    wr(8'h0C, 8'h3F);
    wr32(8'h04, 32'h3000);
    wr32(8'h08, 32'h30FF);
    wr(8'h01, 8'h01);
    beat_ok = 1'b1;
    @(negedge clk); @(negedge clk);
    beat_ok = 1'b0;
    check("R4 two beats", beat_addr, 32'h3008);
    wr(8'h02, 8'h01);
    check("R6 run cleared", run, 0);
    rd(8'h0C, d); check("R6 no done", d, 8'h00);
  endtask

  task automatic t_irq();
    logic [7:0] d;
    t_period(32'h4000, 32'h4007, 0, "irq");
    check("R10 muted", irq, 0);
    rd(8'h0C, d); check("R11 raw while muted", d, 8'h04);
    wr(8'h0D, 8'h3B);
    check("R10 masked", irq, 0);
    wr(8'h0E, 8'h7F);
    check("R10 irq high", irq, 1);
    wr(8'h0C, 8'h04);
    check("R9 w1c irq drops", irq, 0);
    rd(8'h0C, d); check("R9 cleared", d, 8'h00);
    wr(8'h0E, 8'hFF);
    wr(8'h0D, 8'h3F);
  endtask

  task automatic t_events();
    logic [7:0] d;
    @(negedge clk); ev_error = 1; @(negedge clk); ev_error = 0;
    rd(8'h0C, d); check("R9 error set", d, 8'h20);
    check("R10 muted error", irq, 0);
    wr(8'h0D, 8'h1F);
    check("R10 mask still on", irq, 0);
    wr(8'h0E, 8'hDF);
    check("R10 error irq", irq, 1);
    ev_error = 1;
    wr(8'h0C, 8'h20);
    ev_error = 0;
    rd(8'h0C, d); check("R9 set wins", d, 8'h20);
    wr(8'h0C, 8'h20);
    rd(8'h0C, d); check("R9 clear", d, 8'h00);
    @(negedge clk); ev_full = 1; ev_empty = 1; ev_retry = 1; ev_lost = 1;
    @(negedge clk); ev_full = 0; ev_empty = 0; ev_retry = 0; ev_lost = 0;
    rd(8'h0C, d); check("R11 raw full empty retry lost", d, 8'h1B);
    check("R10 others muted", irq, 0);
    wr(8'h0C, 8'h02);
    rd(8'h0C, d); check("R9 partial clear", d, 8'h19);
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cfg();
    t_thr();
    t_addr();
    t_period(32'h1000, 32'h100F, 0, "steady");
    t_period(32'h2000, 32'h2007, 1, "gappy");
    t_period(32'h5004, 32'h5007, 0, "single");
    t_halt();
    t_irq();
    t_events();
    finish_up();
  end
endmodule